// File: doc/BRIEF.md
# Four-Port Indirect RAM Address Generator

This block lets a CPU reach a 2 MiB byte-wide external RAM through four independent pointer ports. Each port keeps a 24-bit base, a 16-bit offset, a 16-bit step and a 7-bit control byte. The CPU programs a port through a small register window in the I/O page. It then moves bytes through a data window. The block forms the RAM address for that window and moves the port's pointers after every data access. The CPU can then stream through tables without reloading addresses.

The effective address is the base. When the port enables it, the offset is added, and the offset can also be treated as signed. After an access, the step goes either to the base or to the offset. A trigger that the CPU selects can fold the offset into the base. It fires on a write to the offset low byte, on a write to the offset high byte, or on a write to a strobe register. The RAM has a combinational read and a clocked write. An access that hits no region of the block returns the pass-through byte it was given.

Top module: `ac_ptr_ram_gen`

## Requirements
- R1: A synchronous active-high reset clears the base, offset, step and control of every port, so all of them read back as zero.
- R2: The RAM address is the low 21 bits of the base. When control bit 1 is set, the zero-extended offset is added. When control bits 1 and 3 are both set, 0xFF0000 is also added.
- R3: A data access on a port whose control bits 0 and 4 are both set adds the step to the base, wrapping at 24 bits.
- R4: A data access on a port with control bit 0 set and bit 4 clear adds the step to the offset, wrapping at 16 bits.
- R5: A data access uses the pointer values from before its own update. The update commits on the clock edge of that access.
- R6: Control bits 6:5 select the fold trigger: 0 none, 1 an offset low-byte write, 2 an offset high-byte write, 3 a write to register 0x0A. A fold sets base = (base + offset + (0xFF0000 if control bit 3)) mod 2^24 and uses the offset byte written in that same cycle. No fold happens on any other trigger.
- R7: Port register readback works as follows. Registers 0x02, 0x03 and 0x04 hold the base, low byte first. Registers 0x05 and 0x06 hold the offset and 0x07 and 0x08 hold the step, low byte first. Register 0x09 holds the control with bit 7 reading 0. Register 0x0A reads 0x00 and registers 0x0B to 0x0F read 0xFF.
- R8: With bank 0xFF, page offsets 0x1A00 to 0x1A3F form the register window. Offset bits 5:4 pick the port and bits 3:0 pick the register. Registers 0x00 and 0x01 are the data window.
- R9: Banks 0x40 to 0x43 are direct data windows for ports 0 to 3, at any page offset.
- R10: With bank 0xFF, offset 0x1AFE reads 0x10 and offset 0x1AFF reads 0x51.
- R11: An access outside every region returns pass_rdata unchanged, leaves all port state as it was, and keeps ram_we low.
- R12: Control bit 2 is stored and read back, but it changes neither the address nor the pointer update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_bank | input | 8 | Bank number of the current CPU access |
| cpu_addr | input | 13 | Offset within the 8 KiB bank |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_wdata | input | 8 | Write byte |
| pass_rdata | input | 8 | Byte returned when the access misses this block |
| cpu_rdata | output | 8 | Read byte, combinational |
| ram_addr | output | 21 | RAM byte address |
| ram_wdata | output | 8 | RAM write byte |
| ram_we | output | 1 | RAM write enable |
| ram_rdata | input | 8 | RAM read byte, combinational |

## Verification
Two pairs of functions can land on one clock edge. A data access and its auto-increment share an edge. So do an offset byte write and the fold that byte triggers. The bench samples ram_addr in the strobe cycle and reads the pointers back afterwards. The address must show the old pointers and the readback must show the stepped pointers, including wraps at 24 and 16 bits. For folds, the expected base is computed with the newly written offset byte, under each of the three triggers and with the signed-offset bit set.

// File: rtl/ac_ptr_ram_gen.sv
module ac_ptr_ram_gen #(
  parameter int RAM_AW = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        cpu_bank,
  input  logic [12:0]       cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [7:0]        cpu_wdata,
  input  logic [7:0]        pass_rdata,
  output logic [7:0]        cpu_rdata,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              ram_we,
  input  logic [7:0]        ram_rdata
);
  localparam int NP = 4;

  logic [23:0] base_q [NP];
  logic [15:0] ofs_q  [NP];
  logic [15:0] inc_q  [NP];
  logic [6:0]  ctl_q  [NP];

  wire reg_page = cpu_bank == 8'hFF;
  wire port_win = reg_page && cpu_addr[12:6] == 7'h68;
  wire id_hit   = reg_page && cpu_addr[12:1] == 12'hD7F;
  wire bank_win = cpu_bank[7:2] == 6'b010000;
  wire [1:0] sp = bank_win ? cpu_bank[1:0] : cpu_addr[5:4];
  wire [3:0] ri = cpu_addr[3:0];
  wire data_hit = bank_win || (port_win && ri <= 4'h1);
  wire acc      = data_hit && (cpu_rd || cpu_wr);
  wire reg_wr   = port_win && cpu_wr && !data_hit;

  wire [23:0] s_base = base_q[sp];
  wire [15:0] s_ofs  = ofs_q[sp];
  wire [15:0] s_inc  = inc_q[sp];
  wire [6:0]  s_ctl  = ctl_q[sp];
  wire [1:0]  trig   = s_ctl[6:5];

  wire [RAM_AW-1:0] ext_a = s_ctl[3] ? RAM_AW'(24'hFF0000) : '0;
  wire [RAM_AW-1:0] add_a = s_ctl[1] ? RAM_AW'(s_ofs) + ext_a : '0;
  assign ram_addr  = s_base[RAM_AW-1:0] + add_a;
  assign ram_we    = data_hit && cpu_wr;
  assign ram_wdata = cpu_wdata;

  wire [15:0] ofs_w = (ri == 4'h5) ? {s_ofs[15:8], cpu_wdata} :
                      (ri == 4'h6) ? {cpu_wdata, s_ofs[7:0]} : s_ofs;
  wire [23:0] fold_base = s_base + {8'd0, ofs_w} + (s_ctl[3] ? 24'hFF0000 : 24'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NP; i++) begin
        base_q[i] <= '0;
        ofs_q[i]  <= '0;
        inc_q[i]  <= '0;
        ctl_q[i]  <= '0;
      end
    end else begin
      if (acc && s_ctl[0]) begin
        if (s_ctl[4]) base_q[sp] <= s_base + {8'd0, s_inc};
        else          ofs_q[sp]  <= s_ofs + s_inc;
      end
      if (reg_wr) begin
        case (ri)
          4'h2: base_q[sp][7:0]   <= cpu_wdata;
          4'h3: base_q[sp][15:8]  <= cpu_wdata;
          4'h4: base_q[sp][23:16] <= cpu_wdata;
          4'h5: begin
            ofs_q[sp] <= ofs_w;
            if (trig == 2'd1) base_q[sp] <= fold_base;
          end
          4'h6: begin
            ofs_q[sp] <= ofs_w;
            if (trig == 2'd2) base_q[sp] <= fold_base;
          end
          4'h7: inc_q[sp][7:0]  <= cpu_wdata;
          4'h8: inc_q[sp][15:8] <= cpu_wdata;
          4'h9: ctl_q[sp]       <= cpu_wdata[6:0];
          4'hA: if (trig == 2'd3) base_q[sp] <= fold_base;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    cpu_rdata = pass_rdata;
    if (data_hit) cpu_rdata = ram_rdata;
    else if (port_win) begin
      case (ri)
        4'h2: cpu_rdata = s_base[7:0];
        4'h3: cpu_rdata = s_base[15:8];
        4'h4: cpu_rdata = s_base[23:16];
        4'h5: cpu_rdata = s_ofs[7:0];
        4'h6: cpu_rdata = s_ofs[15:8];
        4'h7: cpu_rdata = s_inc[7:0];
        4'h8: cpu_rdata = s_inc[15:8];
        4'h9: cpu_rdata = {1'b0, s_ctl};
        4'hA: cpu_rdata = 8'h00;
        default: cpu_rdata = 8'hFF;
      endcase
    end else if (id_hit) cpu_rdata = cpu_addr[0] ? 8'h51 : 8'h10;
  end

  for (genvar p = 0; p < NP; p++) begin : g_chk
    wire sel = sp == 2'(p);

    a_r1_reset_clear: assert property (@(posedge clk)
      rst |=> (base_q[p] == '0 && ofs_q[p] == '0 && inc_q[p] == '0 && ctl_q[p] == '0));

    a_r3_base_step: assert property (@(posedge clk) disable iff (rst)
      (acc && sel && ctl_q[p][0] && ctl_q[p][4]) |=>
        base_q[p] == $past(base_q[p] + {8'd0, inc_q[p]}));

    a_r4_ofs_step: assert property (@(posedge clk) disable iff (rst)
      (acc && sel && ctl_q[p][0] && !ctl_q[p][4]) |=>
        (ofs_q[p] == $past(ofs_q[p] + inc_q[p]) && $stable(base_q[p])));

    a_r6_strobe_fold: assert property (@(posedge clk) disable iff (rst)
      (reg_wr && sel && ri == 4'hA && ctl_q[p][6:5] == 2'd3) |=>
        base_q[p] == $past(base_q[p] + {8'd0, ofs_q[p]} +
                           (ctl_q[p][3] ? 24'hFF0000 : 24'd0)));

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
      !(acc || reg_wr) |=>
        ($stable(base_q[p]) && $stable(ofs_q[p]) && $stable(inc_q[p]) && $stable(ctl_q[p])));
  end
endmodule

// File: tb/test_ac_ptr_ram_gen.sv
module test_ac_ptr_ram_gen;
  logic clk = 0, rst = 1;
  logic [7:0] cpu_bank = 0;
  logic [12:0] cpu_addr = 0;
  logic cpu_rd = 0, cpu_wr = 0;
  logic [7:0] cpu_wdata = 0;
  logic [7:0] pass_rdata = 8'hC3;
  logic [7:0] cpu_rdata, ram_wdata, ram_rdata;
  logic [20:0] ram_addr;
  logic ram_we;
  logic [7:0] mem [1024];
  int errors = 0, checks = 0;
  logic [20:0] last_addr;
  logic last_we;
  logic [7:0] last_rd;
  bit done = 0;

  always #5 clk = ~clk;

  ac_ptr_ram_gen i_ac_ptr_ram_gen (
    .clk, .rst, .cpu_bank, .cpu_addr, .cpu_rd, .cpu_wr, .cpu_wdata, .pass_rdata,
    .cpu_rdata, .ram_addr, .ram_wdata, .ram_we, .ram_rdata);

  assign ram_rdata = mem[ram_addr[9:0]];
  always @(posedge clk) if (ram_we) mem[ram_addr[9:0]] <= ram_wdata;

  localparam logic [37:0] VEC [27] = '{
    {1'b1, 8'hFF, 13'h1A22, 8'h11, 8'h00},
    {1'b1, 8'hFF, 13'h1A23, 8'h22, 8'h00},
    {1'b1, 8'hFF, 13'h1A24, 8'h33, 8'h00},
    {1'b1, 8'hFF, 13'h1A25, 8'h44, 8'h00},
    {1'b1, 8'hFF, 13'h1A26, 8'h55, 8'h00},
    {1'b1, 8'hFF, 13'h1A27, 8'h66, 8'h00},
    {1'b1, 8'hFF, 13'h1A28, 8'h77, 8'h00},
    {1'b1, 8'hFF, 13'h1A29, 8'hFF, 8'h00},
    {1'b0, 8'hFF, 13'h1A22, 8'h00, 8'h11},
    {1'b0, 8'hFF, 13'h1A23, 8'h00, 8'h22},
    {1'b0, 8'hFF, 13'h1A24, 8'h00, 8'h33},
    {1'b0, 8'hFF, 13'h1A25, 8'h00, 8'h44},
    {1'b0, 8'hFF, 13'h1A26, 8'h00, 8'h55},
    {1'b0, 8'hFF, 13'h1A27, 8'h00, 8'h66},
    {1'b0, 8'hFF, 13'h1A28, 8'h00, 8'h77},
    {1'b0, 8'hFF, 13'h1A29, 8'h00, 8'h7F},
    {1'b0, 8'hFF, 13'h1A2A, 8'h00, 8'h00},
    {1'b0, 8'hFF, 13'h1A2B, 8'h00, 8'hFF},
    {1'b0, 8'hFF, 13'h1A2F, 8'h00, 8'hFF},
    {1'b0, 8'hFF, 13'h1A12, 8'h00, 8'h00},
    {1'b0, 8'hFF, 13'h1AFE, 8'h00, 8'h10},
    {1'b0, 8'hFF, 13'h1AFF, 8'h00, 8'h51},
    {1'b0, 8'hFF, 13'h1A40, 8'h00, 8'hC3},
    {1'b0, 8'h44, 13'h0000, 8'h00, 8'hC3},
    {1'b0, 8'h3F, 13'h1A22, 8'h00, 8'hC3},
    {1'b1, 8'hFF, 13'h1A40, 8'h99, 8'h00},
    {1'b0, 8'hFF, 13'h1A22, 8'h00, 8'h11}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(logic w, logic [7:0] b, logic [12:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_bank = b; cpu_addr = a; cpu_wdata = d; cpu_wr = w; cpu_rd = !w;
    #2;
    last_addr = ram_addr; last_we = ram_we; last_rd = cpu_rdata;
    @(posedge clk);
    #1 cpu_wr = 0; cpu_rd = 0;
  endtask

  function automatic logic [12:0] ra(int p, int r);
    return 13'h1A00 | 13'(p << 4) | 13'(r);
  endfunction

  task automatic wreg(int p, int r, logic [7:0] d);
    op(1'b1, 8'hFF, ra(p, r), d);
  endtask

  task automatic rreg(string req, int p, int r, logic [7:0] exp);
    op(1'b0, 8'hFF, ra(p, r), 8'h00);
    chk(req, {24'd0, last_rd}, {24'd0, exp});
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    for (int r = 2; r <= 9; r++) rreg("R1 reset", 0, r, 8'h00);

    for (int i = 0; i < 27; i++) begin
      if (VEC[i][37]) op(1'b1, VEC[i][36:29], VEC[i][28:16], VEC[i][15:8]);
      else begin
        op(1'b0, VEC[i][36:29], VEC[i][28:16], 8'h00);
        chk("R7,R8,R10,R11 vector", {24'd0, last_rd}, {24'd0, VEC[i][7:0]});
      end
    end

    wreg(0, 2, 8'hF0); wreg(0, 3, 8'hFF); wreg(0, 4, 8'h1F);
    wreg(0, 5, 8'h20); wreg(0, 6, 8'h00); wreg(0, 9, 8'h02);
    op(1'b0, 8'h40, 13'h0ABC, 8'h00);
    chk("R2 unsigned offset", {11'd0, last_addr}, 32'h000010);
    wreg(0, 9, 8'h0A);
    op(1'b0, 8'h40, 13'h0000, 8'h00);
    chk("R2 signed offset", {11'd0, last_addr}, 32'h1F0010);
    wreg(0, 9, 8'h00);
    op(1'b0, 8'h40, 13'h1FFF, 8'h00);
    chk("R2 base only", {11'd0, last_addr}, 32'h1FFFF0);

    wreg(1, 2, 8'hFE); wreg(1, 3, 8'hFF); wreg(1, 4, 8'hFF);
    wreg(1, 7, 8'h03); wreg(1, 8, 8'h00); wreg(1, 9, 8'h11);
    op(1'b1, 8'hFF, ra(1, 0), 8'hA5);
    chk("R5 pre-step address", {11'd0, last_addr}, 32'h1FFFFE);
    chk("R5 write enable", {31'd0, last_we}, 32'd1);
    rreg("R3 base wrap low", 1, 2, 8'h01);
    rreg("R3 base wrap mid", 1, 3, 8'h00);
    rreg("R3 base wrap high", 1, 4, 8'h00);
    op(1'b0, 8'h41, 13'h1FFF, 8'h00);
    chk("R5 next address", {11'd0, last_addr}, 32'h000001);

    wreg(3, 2, 8'h00); wreg(3, 3, 8'h01); wreg(3, 4, 8'h00);
    wreg(3, 5, 8'hFF); wreg(3, 6, 8'hFF);
    wreg(3, 7, 8'h02); wreg(3, 8, 8'h00); wreg(3, 9, 8'h03);
    op(1'b0, 8'h43, 13'h0123, 8'h00);
    chk("R4 address", {11'd0, last_addr}, 32'h0100FF);
    rreg("R4 offset wrap low", 3, 5, 8'h01);
    rreg("R4 offset wrap high", 3, 6, 8'h00);
    rreg("R4 base untouched", 3, 3, 8'h01);
    wreg(3, 9, 8'h07);
    op(1'b0, 8'h43, 13'h0000, 8'h00);
    chk("R12 address", {11'd0, last_addr}, 32'h000101);
    rreg("R12 offset step", 3, 5, 8'h03);
    rreg("R12 control readback", 3, 9, 8'h07);

    wreg(0, 9, 8'h00); wreg(0, 2, 8'h55); wreg(0, 3, 8'h00); wreg(0, 4, 8'h00);
    op(1'b1, 8'h40, 13'h0777, 8'h3C);
    chk("R9 bank write enable", {31'd0, last_we}, 32'd1);
    rreg("R8 data window read", 0, 1, 8'h3C);
    rreg("R8 no step", 0, 2, 8'h55);

    wreg(0, 2, 8'h00); wreg(0, 3, 8'h10); wreg(0, 4, 8'h00);
    wreg(0, 5, 8'h00); wreg(0, 6, 8'h00); wreg(0, 9, 8'h20);
    wreg(0, 5, 8'h10);
    rreg("R6 low fold low", 0, 2, 8'h10);
    rreg("R6 low fold mid", 0, 3, 8'h10);
    wreg(0, 6, 8'h00);
    rreg("R6 no fold on high", 0, 2, 8'h10);
    wreg(0, 9, 8'h40);
    wreg(0, 6, 8'h01);
    rreg("R6 high fold low", 0, 2, 8'h20);
    rreg("R6 high fold mid", 0, 3, 8'h11);
    wreg(0, 9, 8'h68);
    wreg(0, 10, 8'h00);
    rreg("R6 strobe fold low", 0, 2, 8'h30);
    rreg("R6 strobe fold mid", 0, 3, 8'h12);
    rreg("R6 strobe fold high", 0, 4, 8'hFF);
    wreg(0, 5, 8'h20);
    rreg("R6 no fold on low", 0, 2, 8'h30);

    op(1'b1, 8'h20, 13'h0000, 8'h77);
    chk("R11 no write enable", {31'd0, last_we}, 32'd0);
    rreg("R11 state kept", 0, 2, 8'h30);

    @(negedge clk); rst = 1;
    repeat (2) @(posedge clk);
    #1 rst = 0;
    rreg("R1 reset base", 0, 2, 8'h00);
    rreg("R1 reset control", 3, 9, 8'h00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule